// File: doc/BRIEF.md
# Cache Bring-Up Control Sequencer

This block walks the control register of an external second- or third-level cache through an ordered power-up procedure. Software or a boot controller supplies the wanted final configuration word and a one-cycle start pulse. The sequencer then issues a series of register writes on its own. Each write shows the full control word on `ctrl_out` and carries a one-cycle `ctrl_wr` strobe. Between the writes the sequencer waits fixed, parameter-set numbers of cycles, or it watches an invalidate-pending status that comes back from the cache.

Two procedures are selectable when the sequencer starts. The full procedure suits a cache with a gated clock. It writes a masked base word and then sets a marker bit. It turns the cache clock on, runs a global invalidate and turns the clock off. After a wait it sets enable and clock-enable together, then waits again. The short procedure writes the base word with enable cleared and waits for the clock to settle. It then invalidates, polls until the invalidate completes, and sets enable. The block reports `busy` while a procedure runs and pulses `done` when one finishes. If the invalidate does not complete within a bounded number of cycles, it raises `err` and returns to idle.

States: IDLE waits for start. BASE, MARK, CLKON, INV, CLKOFF and ENABLE each make one write. POLL watches the invalidate status. STAB, OFFWAIT and ONWAIT are counted waits. FIN gives the done pulse. The full procedure runs IDLE→BASE→MARK→CLKON→INV→POLL→CLKOFF→OFFWAIT→ENABLE→ONWAIT→FIN→IDLE. The short procedure runs IDLE→BASE→STAB→INV→POLL→ENABLE→FIN→IDLE. From POLL, a timeout goes to IDLE.

Top module: `cache_bringup_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `err` and `ctrl_wr` are 0.
- R2: The full procedure (`mode`=0) first makes three writes. With the enable bit at 31, the parity-enable bit at 30, the invalidate bit at 10, the clock-enable bit at 3 and a reserved mask of 0x04000180, the base word B is cfg with enable, parity-enable, invalidate, clock-enable and reserved bits all cleared. The three writes are B, then B|0x04000000, then B|0x04000000|bit3.
- R3: The full procedure then writes three more words: B|0x04000000|bit3|bit10 (invalidate), then B|0x04000000 (clock off), then B|0x04000000|bit31|bit3 (enable with clock). That makes six writes in all.
- R4: After the invalidate write, no further write occurs while `inv_pending` is high. The procedure continues once it is low.
- R5: In the full procedure, the enable write appears exactly OFF_WAIT+1 cycles after the clock-off write.
- R6: In the full procedure, `done` is high for exactly one cycle, ON_WAIT cycles after the enable write.
- R7: The short procedure (`mode`=1) makes three writes: S = cfg with bits 31 and 10 cleared, then S|bit10, then S|bit31.
- R8: In the short procedure, the invalidate write appears exactly STAB_WAIT+1 cycles after the base write. `done` pulses for one cycle in the same cycle as the enable write.
- R9: If `inv_pending` stays high for POLL_LIMIT cycles, `err` rises, `busy` falls, no further write occurs and `done` is not pulsed. The next accepted start clears `err`.
- R10: A start pulse while `busy` is high is ignored: the writes of the running procedure are unchanged.
- R11: A synchronous reset in the middle of a procedure drops `busy` and stops all writes, while `ctrl_out` keeps the last written word.
- R12: `busy` rises the cycle after an accepted start and is low again once `done` has pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a procedure |
| mode | input | 1 | 0 = full gated-clock procedure, 1 = short procedure |
| cfg | input | 32 | Wanted final configuration word, captured at start |
| inv_pending | input | 1 | High while the cache is still invalidating |
| ctrl_out | output | 32 | Control word last written to the cache |
| ctrl_wr | output | 1 | One-cycle write strobe for `ctrl_out` |
| busy | output | 1 | A procedure is running |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | Invalidate timed out; cleared by the next start |

## Verification
The assertions assume two things about the inputs. Reset is applied before the first start. `inv_pending` only rises in answer to a write that carries the invalidate bit. The bench's cache model enforces both: it raises `inv_pending` only on seeing such a write, for a random or directed number of cycles. Start pulses are driven between clock edges, including some deliberately issued while the sequencer is busy. Random configuration words set every bit, including reserved and parity bits, so the masking is exercised in both procedures.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    localparam int WORD_W = 32;

    localparam logic [WORD_W-1:0] EN_BIT    = 32'h8000_0000;
    localparam logic [WORD_W-1:0] PAR_BIT   = 32'h4000_0000;
    localparam logic [WORD_W-1:0] INV_BIT   = 32'h0000_0400;
    localparam logic [WORD_W-1:0] CLKEN_BIT = 32'h0000_0008;
    localparam logic [WORD_W-1:0] MARK_BIT  = 32'h0400_0000;
    localparam logic [WORD_W-1:0] RSVD_MASK = 32'h0400_0180;

    typedef enum logic [3:0] {
        S_IDLE,
        S_BASE,
        S_MARK,
        S_CLKON,
        S_INV,
        S_POLL,
        S_CLKOFF,
        S_OFFWAIT,
        S_ENABLE,
        S_ONWAIT,
        S_STAB,
        S_FIN
    } seq_state_t;

endpackage

// File: rtl/cbs_down_ctr.sv
module cbs_down_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/cbs_word_gen.sv
module cbs_word_gen
    import cbs_pkg::*;
(
    input  logic [WORD_W-1:0] cfg,
    input  logic              short_mode,
    input  seq_state_t        state,
    output logic [WORD_W-1:0] word,
    output logic              is_write
);
    logic [WORD_W-1:0] full_base;
    logic [WORD_W-1:0] short_base;
    logic [WORD_W-1:0] marked;

    assign full_base  = cfg & ~(EN_BIT | PAR_BIT | INV_BIT | CLKEN_BIT | RSVD_MASK);
    assign short_base = cfg & ~(EN_BIT | INV_BIT);
    assign marked     = full_base | MARK_BIT;

    always_comb begin
        word     = '0;
        is_write = 1'b1;
        unique case (state)
            S_BASE:   word = short_mode ? short_base : full_base;
            S_MARK:   word = marked;
            S_CLKON:  word = marked | CLKEN_BIT;
            S_INV:    word = short_mode ? (short_base | INV_BIT)
                                        : (marked | CLKEN_BIT | INV_BIT);
            S_CLKOFF: word = marked;
            S_ENABLE: word = short_mode ? (short_base | EN_BIT)
                                        : (marked | EN_BIT | CLKEN_BIT);
            default:  is_write = 1'b0;
        endcase
    end
endmodule

// File: rtl/cache_bringup_seq.sv
module cache_bringup_seq
    import cbs_pkg::*;
#(
    parameter int OFF_WAIT   = 100,
    parameter int ON_WAIT    = 100,
    parameter int STAB_WAIT  = 64,
    parameter int POLL_LIMIT = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        mode,
    input  logic [31:0] cfg,
    input  logic        inv_pending,
    output logic [31:0] ctrl_out,
    output logic        ctrl_wr,
    output logic        busy,
    output logic        done,
    output logic        err
);
    localparam int WAIT_MAX = (OFF_WAIT > ON_WAIT) ?
                              ((OFF_WAIT > STAB_WAIT) ? OFF_WAIT : STAB_WAIT) :
                              ((ON_WAIT > STAB_WAIT) ? ON_WAIT : STAB_WAIT);
    localparam int WCW = $clog2(WAIT_MAX + 1);
    localparam int PCW = $clog2(POLL_LIMIT + 1);
    localparam logic [WCW-1:0] OFF_LD  = WCW'(OFF_WAIT - 1);
    localparam logic [WCW-1:0] ON_LD   = WCW'(ON_WAIT - 1);
    localparam logic [WCW-1:0] STAB_LD = WCW'(STAB_WAIT - 1);
    localparam logic [PCW-1:0] POLL_LD = PCW'(POLL_LIMIT - 1);

    seq_state_t        state, state_nx;
    logic [WORD_W-1:0] cfg_q;
    logic              short_q;
    logic [WORD_W-1:0] word;
    logic              is_write;
    logic              accept;
    logic              timeout_hit;

    logic              w_load, w_dec, w_zero;
    logic [WCW-1:0]    w_val;
    logic              p_load, p_dec, p_zero;

    logic [WORD_W-1:0] ctrl_q;
    logic              wr_q;
    logic              err_q;

    assign accept = (state == S_IDLE) && start;

    cbs_word_gen u_word (
        .cfg        (cfg_q),
        .short_mode (short_q),
        .state      (state),
        .word       (word),
        .is_write   (is_write)
    );

    cbs_down_ctr #(.CW(WCW)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (w_load),
        .load_val (w_val),
        .dec      (w_dec),
        .zero     (w_zero)
    );

    cbs_down_ctr #(.CW(PCW)) u_poll (
        .clk      (clk),
        .rst      (rst),
        .load     (p_load),
        .load_val (POLL_LD),
        .dec      (p_dec),
        .zero     (p_zero)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            cfg_q   <= '0;
            short_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cfg_q   <= cfg;
                short_q <= mode;
            end
        end
    end

    // next state and counter control
    always_comb begin
        state_nx    = state;
        w_load      = 1'b0;
        w_val       = '0;
        w_dec       = 1'b0;
        p_load      = 1'b0;
        p_dec       = 1'b0;
        timeout_hit = 1'b0;
        unique case (state)
            S_IDLE:    if (start) state_nx = S_BASE;
            S_BASE: begin
                if (short_q) begin
                    state_nx = S_STAB;
                    w_load   = 1'b1;
                    w_val    = STAB_LD;
                end else begin
                    state_nx = S_MARK;
                end
            end
            S_MARK:    state_nx = S_CLKON;
            S_CLKON:   state_nx = S_INV;
            S_STAB: begin
                if (w_zero) state_nx = S_INV;
                else        w_dec    = 1'b1;
            end
            S_INV: begin
                state_nx = S_POLL;
                p_load   = 1'b1;
            end
            S_POLL: begin
                if (!inv_pending) begin
                    state_nx = short_q ? S_ENABLE : S_CLKOFF;
                end else if (p_zero) begin
                    state_nx    = S_IDLE;
                    timeout_hit = 1'b1;
                end else begin
                    p_dec = 1'b1;
                end
            end
            S_CLKOFF: begin
                state_nx = S_OFFWAIT;
                w_load   = 1'b1;
                w_val    = OFF_LD;
            end
            S_OFFWAIT: begin
                if (w_zero) state_nx = S_ENABLE;
                else        w_dec    = 1'b1;
            end
            S_ENABLE: begin
                if (short_q) begin
                    state_nx = S_FIN;
                end else begin
                    state_nx = S_ONWAIT;
                    w_load   = 1'b1;
                    w_val    = ON_LD;
                end
            end
            S_ONWAIT: begin
                if (w_zero) state_nx = S_FIN;
                else        w_dec    = 1'b1;
            end
            S_FIN:     state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // registered outputs; the control word is held across reset
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            wr_q <= is_write;
            if (is_write)
                ctrl_q <= word;
            if (accept)
                err_q <= 1'b0;
            else if (timeout_hit)
                err_q <= 1'b1;
        end
    end

    assign ctrl_out = ctrl_q;
    assign ctrl_wr  = wr_q;
    assign err      = err_q;
    assign busy     = (state != S_IDLE);
    assign done     = (state == S_FIN);

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [31:0] ctrl_out,
    input logic        ctrl_wr,
    input logic        busy,
    input logic        done,
    input logic        err
);
    // R6 R8: completion pulse lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12: after done the sequencer is idle
    a_r12_done_then_idle: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R12: busy only rises after a start request
    a_r12_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R4: writes only appear during a running procedure
    a_r4_write_when_busy: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |-> busy);

    // R3 R7: invalidate never issued together with enable
    a_r3_inv_not_enabled: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_out[10]) |-> !ctrl_out[31]);

    // R9: a timeout leaves the sequencer idle without a completion pulse
    a_r9_err_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (!busy && !done));
endmodule

bind cache_bringup_seq cbs_checker u_cbs_checker (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .ctrl_out (ctrl_out),
    .ctrl_wr  (ctrl_wr),
    .busy     (busy),
    .done     (done),
    .err      (err)
);

// File: tb/tb_cache_bringup_seq.sv
`timescale 1ns/1ps
module tb_cache_bringup_seq;
    localparam int OFFW = 100;
    localparam int ONW  = 100;
    localparam int STW  = 64;
    localparam int PLIM = 1000;

    localparam logic [31:0] B_EN   = 32'h8000_0000;
    localparam logic [31:0] B_PAR  = 32'h4000_0000;
    localparam logic [31:0] B_INV  = 32'h0000_0400;
    localparam logic [31:0] B_CLK  = 32'h0000_0008;
    localparam logic [31:0] B_MARK = 32'h0400_0000;
    localparam logic [31:0] B_RSV  = 32'h0400_0180;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] cfg = '0;
    logic        inv_pending = 1'b0;
    logic [31:0] ctrl_out;
    logic        ctrl_wr, busy, done, err;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int nwr = 0;
    int done_cnt = 0;
    int done_cyc = 0;
    int wr_in_pend = 0;
    int pend_left = 0;
    int pend_len = 0;
    logic [31:0] wr_val [0:15];
    int          wr_cyc [0:15];

    always #10 clk = ~clk;

    cache_bringup_seq #(
        .OFF_WAIT(OFFW), .ON_WAIT(ONW), .STAB_WAIT(STW), .POLL_LIMIT(PLIM)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .cfg(cfg),
        .inv_pending(inv_pending), .ctrl_out(ctrl_out), .ctrl_wr(ctrl_wr),
        .busy(busy), .done(done), .err(err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor and cache model, away from the active edge
    always @(negedge clk) begin
        if (ctrl_wr) begin
            if (inv_pending) wr_in_pend++;
            if (nwr < 16) begin
                wr_val[nwr] = ctrl_out;
                wr_cyc[nwr] = cyc;
            end
            nwr++;
        end
        if (done) begin
            done_cnt++;
            done_cyc = cyc;
        end
        if (ctrl_wr && ctrl_out[10])
            pend_left = pend_len;
        else if (pend_left > 0)
            pend_left--;
        inv_pending = (pend_left != 0);
    end

    function automatic logic [31:0] exp_word(input logic m, input logic [31:0] c, input int i);
        logic [31:0] b, s;
        b = c & ~(B_EN | B_PAR | B_INV | B_CLK | B_RSV);
        s = c & ~(B_EN | B_INV);
        if (!m) begin
            case (i)
                0: return b;
                1: return b | B_MARK;
                2: return b | B_MARK | B_CLK;
                3: return b | B_MARK | B_CLK | B_INV;
                4: return b | B_MARK;
                default: return b | B_MARK | B_EN | B_CLK;
            endcase
        end else begin
            case (i)
                0: return s;
                1: return s | B_INV;
                default: return s | B_EN;
            endcase
        end
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic clear_log();
        nwr = 0; done_cnt = 0; wr_in_pend = 0;
    endtask

    task automatic pulse_start(input logic m, input logic [31:0] c);
        @(posedge clk); #2;
        start = 1'b1; mode = m; cfg = c;
        @(posedge clk); #2;
        start = 1'b0; cfg = ~c; mode = ~m;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 3000; k++) begin
            @(posedge clk); #2;
            if (done_cnt != 0 || err) break;
        end
        repeat (3) @(posedge clk);
        #2;
    endtask

    task automatic check_run(input logic m, input logic [31:0] c);
        int expn;
        expn = m ? 3 : 6;
        chk(nwr == expn, m ? "R7 write count" : "R3 write count", nwr, expn);
        for (int i = 0; i < expn && i < nwr; i++)
            chk(wr_val[i] == exp_word(m, c, i), m ? "R7 word" : (i < 3 ? "R2 word" : "R3 word"),
                wr_val[i], exp_word(m, c, i));
        chk(wr_in_pend == 0, "R4 write during pending", wr_in_pend, 0);
        chk(done_cnt == 1, "R6 R8 done pulses", done_cnt, 1);
        chk(!busy, "R12 idle after done", busy, 0);
        if (nwr == expn) begin
            if (!m) begin
                chk(wr_cyc[5] - wr_cyc[4] == OFFW + 1, "R5 clock-off wait",
                    wr_cyc[5] - wr_cyc[4], OFFW + 1);
                chk(done_cyc - wr_cyc[5] == ONW, "R6 done delay",
                    done_cyc - wr_cyc[5], ONW);
            end else begin
                chk(wr_cyc[1] - wr_cyc[0] == STW + 1, "R8 stabilise wait",
                    wr_cyc[1] - wr_cyc[0], STW + 1);
                chk(done_cyc == wr_cyc[2], "R8 done with enable",
                    done_cyc, wr_cyc[2]);
            end
        end
    endtask

    task automatic run_one(input logic m, input logic [31:0] c, input int pl);
        int t_inv;
        pend_len = pl;
        clear_log();
        pulse_start(m, c);
        chk(busy, "R12 busy after start", busy, 1);
        wait_end();
        check_run(m, c);
        if (nwr >= 2) begin
            t_inv = m ? 1 : 3;
            if (nwr > t_inv + 1)
                chk(wr_cyc[t_inv + 1] - wr_cyc[t_inv] >= pl, "R4 poll holds",
                    wr_cyc[t_inv + 1] - wr_cyc[t_inv], pl);
        end
    endtask

    initial begin
        #(20 * 150000);
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        int seed;
        logic [31:0] c0;
        logic [31:0] last;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        #2; rst = 1'b0;
        #1;
        chk(!busy && !done && !err && !ctrl_wr, "R1 reset state",
            {busy, done, err, ctrl_wr}, 0);

        // directed: all ones, both procedures, zero and long pending
        run_one(1'b0, 32'hFFFF_FFFF, 0);
        run_one(1'b1, 32'hFFFF_FFFF, 0);
        run_one(1'b0, 32'h0000_0000, 37);
        run_one(1'b1, 32'h0000_0000, 12);

        // random runs
        for (int r = 0; r < 12; r++)
            run_one(1'($urandom_range(0, 1)), $urandom, $urandom_range(0, 40));

        // R9 timeout
        pend_len = 100000;
        clear_log();
        pulse_start(1'b0, 32'h1234_5678);
        wait_end();
        chk(err, "R9 err raised", err, 1);
        chk(!busy, "R9 idle after timeout", busy, 0);
        chk(nwr == 4, "R9 no write after invalidate", nwr, 4);
        chk(done_cnt == 0, "R9 no done", done_cnt, 0);
        pend_left = 0; pend_len = 5;
        repeat (2) @(posedge clk);
        #2;
        clear_log();
        pulse_start(1'b1, 32'h0F0F_0F0F);
        chk(!err, "R9 err cleared by start", err, 0);
        wait_end();
        check_run(1'b1, 32'h0F0F_0F0F);

        // R10 start while busy
        c0 = $urandom;
        pend_len = 8;
        clear_log();
        pulse_start(1'b0, c0);
        repeat (3) @(posedge clk);
        pulse_start(1'b1, ~c0);
        repeat (150) @(posedge clk);
        pulse_start(1'b1, 32'hDEAD_BEEF);
        wait_end();
        chk(nwr == 6, "R10 writes unchanged count", nwr, 6);
        for (int i = 0; i < 6 && i < nwr; i++)
            chk(wr_val[i] == exp_word(1'b0, c0, i), "R10 word unchanged",
                wr_val[i], exp_word(1'b0, c0, i));

        // R11 reset mid-procedure
        c0 = 32'hA5A5_5A5A;
        pend_len = 4;
        clear_log();
        pulse_start(1'b0, c0);
        for (int k = 0; k < 500 && nwr < 5; k++) @(posedge clk);
        repeat (5) @(posedge clk);
        #2;
        last = ctrl_out;
        rst = 1'b1;
        @(posedge clk); #2;
        rst = 1'b0;
        chk(!busy, "R11 busy dropped", busy, 0);
        clear_log();
        repeat (300) @(posedge clk);
        #2;
        chk(nwr == 0, "R11 no writes after reset", nwr, 0);
        chk(ctrl_out == last, "R11 control word held", ctrl_out, last);
        chk(last == exp_word(1'b0, c0, 4), "R11 held word is clock-off", last,
            exp_word(1'b0, c0, 4));
        chk(done_cnt == 0 && !err, "R11 no done or err", done_cnt, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule